// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block sits beside an 8-bit processor's control unit and handles every way into and back out of a service routine. At each instruction boundary it decides whether a hardware request, a software break or a return-from-interrupt is to run. It then steps through the stack and vector accesses on a byte-wide memory port, one access per state. At the end it hands the core a single write strobe that carries the new program counter, status byte and stack pointer.

The core owns the architectural registers. It presents the address of the instruction about to start (`next_pc`), its status byte and its stack pointer. It pulses `boundary` when that instruction may begin, and raises `brk_cmd` or `rti_cmd` alongside `boundary` when decode has found a break or a return. While `busy` is high the core stalls. It copies `pc_wdata`, `p_wdata` and `sp_wdata` into its registers on the cycle `arch_wr` is high.

The memory port is a valid/ready request channel. A request is accepted on a clock edge where `mem_valid` and `mem_ready` are both high. For a read, `mem_rdata` must be valid in that same cycle. While `mem_ready` is low, the block holds the request unchanged and does not advance. Memory can stall for any number of cycles, and this back-pressure is the only flow control.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy`, `mem_valid`, `arch_wr` and `done` are low, and no memory request is made until a sequence starts.
- R2: A maskable request (`irq_n` low, level-sensitive) starts an entry at a boundary only when status bit 2 (interrupt disable) is 0. When that bit is 1 the boundary passes with `busy` staying low.
- R3: A high-to-low transition of `nmi_n` is latched and taken at the next boundary whatever status bit 2 holds. Holding `nmi_n` low afterwards does not start another entry.
- R4: When several sources compete at one boundary, the order is non-maskable first, then maskable, then break, then return. A preempted break or return is not carried out, so the pushed return address is `next_pc` rather than `next_pc`+2.
- R5: Entry writes three bytes to 0x0100+SP with post-decrement. The order is PC high byte, then PC low byte, then status. The SP written back is SP-3.
- R6: The pushed return address is `next_pc` for a hardware request and `next_pc`+2 for a break.
- R7: The pushed status byte equals the current status with bit 4 set to 1 for a break and 0 for a hardware request.
- R8: The non-maskable vector is read from 0xFFFA (low byte) and 0xFFFB (high byte). Maskable and break entries read it from 0xFFFE and 0xFFFF. On entry the written PC is that vector, and the written status has bit 2 set and bit 4 cleared.
- R9: A break starts its entry even when status bit 2 is 1.
- R10: A return reads status, PC low byte and PC high byte from 0x0100+SP+1 with pre-increment, in that order. It writes back the PC exactly as pulled, with no adjustment, together with the pulled status with bit 4 cleared and SP+3.
- R11: The completion cycle of any sequence acts as a boundary for hardware requests, using the freshly written status. A maskable request still low after a return that cleared bit 2 therefore re-enters at once. A non-maskable edge that arrives during a sequence is serviced right after it, pushing the freshly loaded PC.
- R12: With `mem_ready` held high, `done` is high for one cycle, 7 clock edges after the boundary edge for an entry and 5 for a return. `arch_wr` is high in the cycle just before `done`.
- R13: While `mem_valid` is high and `mem_ready` low, `mem_addr`, `mem_we` and `mem_wdata` stay stable, and the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, taken on its falling edge |
| boundary | input | 1 | Instruction boundary strobe from the core |
| brk_cmd | input | 1 | Decode found a break instruction at `next_pc` |
| rti_cmd | input | 1 | Decode found a return-from-interrupt at `next_pc` |
| next_pc | input | 16 | Address of the instruction about to start |
| flags_in | input | 8 | Current status byte (bit 2 disable, bit 4 break) |
| sp_in | input | 8 | Current stack pointer |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the accepting cycle |
| busy | output | 1 | A sequence is running; the core stalls |
| arch_wr | output | 1 | Core loads PC, status and SP this cycle |
| pc_wdata | output | 16 | New program counter |
| p_wdata | output | 8 | New status byte |
| sp_wdata | output | 8 | New stack pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the cases where sources collide or overlap. One case has a break decoded in the same boundary as a non-maskable edge and a low maskable line. A design with the wrong order would fetch the wrong vector or push the break's +2 address. Another case is a return that clears the disable bit while the maskable line is still low. A design that waits for the next boundary would let one handler instruction slip through, so the bench expects the second entry with no boundary at all. A non-maskable edge injected in the middle of an entry must push the handler start address. The bench also checks that a non-maskable line held low is taken only once, that the status is restored with bit 4 cleared, and that random memory stalls give the same stack image, only later.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_H,
    ST_PUSH_L,
    ST_PUSH_P,
    ST_VEC_L,
    ST_VEC_H,
    ST_PULL_P,
    ST_PULL_L,
    ST_PULL_H,
    ST_LOAD,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_IRQ,
    SRC_NMI,
    SRC_BRK,
    SRC_RTI
  } seq_src_e;

endpackage

// File: rtl/nmi_edge_latch.sv
`timescale 1ns/1ps
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic clr,
  output logic pend
);

  logic nmi_prev;
  logic fall;

  assign fall = nmi_prev & ~nmi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b1;
      pend     <= 1'b0;
    end else begin
      nmi_prev <= nmi_n;
      // a fresh edge wins over a clear in the same cycle
      pend     <= fall | (pend & ~clr);
    end
  end

endmodule

// File: rtl/entry_arbiter.sv
`timescale 1ns/1ps
module entry_arbiter
  import irq_seq_pkg::*;
(
  input  logic     eval,
  input  logic     sw_ok,
  input  logic     nmi_pend,
  input  logic     irq_n,
  input  logic     i_flag,
  input  logic     brk_cmd,
  input  logic     rti_cmd,
  output logic     start,
  output seq_src_e src
);

  always_comb begin
    start = 1'b0;
    src   = SRC_IRQ;
    if (eval) begin
      if (nmi_pend) begin
        start = 1'b1;
        src   = SRC_NMI;
      end else if (!irq_n && !i_flag) begin
        start = 1'b1;
        src   = SRC_IRQ;
      end else if (sw_ok && brk_cmd) begin
        start = 1'b1;
        src   = SRC_BRK;
      end else if (sw_ok && rti_cmd) begin
        start = 1'b1;
        src   = SRC_RTI;
      end
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int                   DW       = 8,
  parameter int                   I_POS    = 2,
  parameter int                   B_POS    = 4,
  parameter int                   BRK_LEN  = 2,
  parameter logic [DW-1:0]        STACK_HI = 8'h01,
  parameter logic [2*DW-1:0]      VEC_NMI  = 16'hFFFA,
  parameter logic [2*DW-1:0]      VEC_IRQ  = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n,
  input  logic              nmi_n,
  input  logic              boundary,
  input  logic              brk_cmd,
  input  logic              rti_cmd,
  input  logic [2*DW-1:0]   next_pc,
  input  logic [DW-1:0]     flags_in,
  input  logic [DW-1:0]     sp_in,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [2*DW-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic              arch_wr,
  output logic [2*DW-1:0]   pc_wdata,
  output logic [DW-1:0]     p_wdata,
  output logic [DW-1:0]     sp_wdata,
  output logic              done
);

  localparam int              AW       = 2 * DW;
  localparam logic [AW-1:0]   BRK_STEP = AW'(BRK_LEN);
  localparam logic [AW-1:0]   ONE_A    = AW'(1);
  localparam logic [DW-1:0]   ONE_D    = DW'(1);

  seq_state_e    state;
  seq_src_e      src;
  logic [AW-1:0] ret_pc;
  logic [DW-1:0] flg;
  logic [DW-1:0] sp;
  logic [DW-1:0] vec_lo;

  logic          nmi_pend;
  logic          nmi_clr;
  logic          eval;
  logic          sw_ok;
  logic          i_now;
  logic          start;
  seq_src_e      start_src;
  logic          xfer;
  logic [AW-1:0] vec_base;
  logic [DW-1:0] push_flags;
  logic [DW-1:0] load_flags;

  // boundary decisions: at a core boundary while idle, or on the completion cycle
  assign eval  = (state == ST_IDLE && boundary) || (state == ST_DONE);
  assign sw_ok = (state == ST_IDLE);
  assign i_now = (state == ST_DONE) ? flg[I_POS] : flags_in[I_POS];
  assign xfer  = mem_valid & mem_ready;

  nmi_edge_latch u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .nmi_n (nmi_n),
    .clr   (nmi_clr),
    .pend  (nmi_pend)
  );

  entry_arbiter u_arb (
    .eval     (eval),
    .sw_ok    (sw_ok),
    .nmi_pend (nmi_pend),
    .irq_n    (irq_n),
    .i_flag   (i_now),
    .brk_cmd  (brk_cmd),
    .rti_cmd  (rti_cmd),
    .start    (start),
    .src      (start_src)
  );

  // latch cleared as the non-maskable vector fetch begins
  assign nmi_clr  = (state == ST_PUSH_P) && xfer && (src == SRC_NMI);
  assign vec_base = (src == SRC_NMI) ? VEC_NMI : VEC_IRQ;

  always_comb begin
    push_flags        = flg;
    push_flags[B_POS] = (src == SRC_BRK);
    load_flags        = flg;
    load_flags[B_POS] = 1'b0;
    if (src != SRC_RTI) load_flags[I_POS] = 1'b1;
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_PUSH_H: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {STACK_HI, sp};
        mem_wdata = ret_pc[AW-1:DW];
      end
      ST_PUSH_L: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {STACK_HI, sp};
        mem_wdata = ret_pc[DW-1:0];
      end
      ST_PUSH_P: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {STACK_HI, sp};
        mem_wdata = push_flags;
      end
      ST_VEC_L: begin
        mem_valid = 1'b1;
        mem_addr  = vec_base;
      end
      ST_VEC_H: begin
        mem_valid = 1'b1;
        mem_addr  = vec_base + ONE_A;
      end
      ST_PULL_P, ST_PULL_L, ST_PULL_H: begin
        mem_valid = 1'b1;
        mem_addr  = {STACK_HI, sp + ONE_D};
      end
      default: ;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign arch_wr  = (state == ST_LOAD);
  assign pc_wdata = ret_pc;
  assign p_wdata  = load_flags;
  assign sp_wdata = sp;
  assign done     = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      src    <= SRC_IRQ;
      ret_pc <= '0;
      flg    <= '0;
      sp     <= '0;
      vec_lo <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          src    <= start_src;
          sp     <= sp_in;
          flg    <= flags_in;
          ret_pc <= (start_src == SRC_BRK) ? next_pc + BRK_STEP : next_pc;
          state  <= (start_src == SRC_RTI) ? ST_PULL_P : ST_PUSH_H;
        end
        ST_PUSH_H: if (xfer) begin
          sp    <= sp - ONE_D;
          state <= ST_PUSH_L;
        end
        ST_PUSH_L: if (xfer) begin
          sp    <= sp - ONE_D;
          state <= ST_PUSH_P;
        end
        ST_PUSH_P: if (xfer) begin
          sp    <= sp - ONE_D;
          state <= ST_VEC_L;
        end
        ST_VEC_L: if (xfer) begin
          vec_lo <= mem_rdata;
          state  <= ST_VEC_H;
        end
        ST_VEC_H: if (xfer) begin
          ret_pc <= {mem_rdata, vec_lo};
          state  <= ST_LOAD;
        end
        ST_PULL_P: if (xfer) begin
          sp    <= sp + ONE_D;
          flg   <= mem_rdata;
          state <= ST_PULL_L;
        end
        ST_PULL_L: if (xfer) begin
          sp             <= sp + ONE_D;
          ret_pc[DW-1:0] <= mem_rdata;
          state          <= ST_PULL_H;
        end
        ST_PULL_H: if (xfer) begin
          sp              <= sp + ONE_D;
          ret_pc[AW-1:DW] <= mem_rdata;
          state           <= ST_LOAD;
        end
        ST_LOAD: begin
          flg   <= load_flags;
          state <= ST_DONE;
        end
        ST_DONE: begin
          if (start) begin
            src   <= start_src;
            state <= ST_PUSH_H;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_seq_chk.sv
`timescale 1ns/1ps
module irq_entry_seq_chk #(
  parameter int              DW       = 8,
  parameter int              B_POS    = 4,
  parameter logic [DW-1:0]   STACK_HI = 8'h01,
  parameter logic [2*DW-1:0] VEC_NMI  = 16'hFFFA,
  parameter logic [2*DW-1:0] VEC_IRQ  = 16'hFFFE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [2*DW-1:0]   mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic              busy,
  input logic              arch_wr,
  input logic [DW-1:0]     p_wdata,
  input logic              done
);

  localparam int AW = 2 * DW;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !arch_wr && !done));

  assert_stack_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_addr[AW-1:DW] == STACK_HI));

  assert_vector_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && mem_addr[AW-1:DW] != STACK_HI) |->
      (mem_addr == VEC_NMI || mem_addr == VEC_NMI + AW'(1) ||
       mem_addr == VEC_IRQ || mem_addr == VEC_IRQ + AW'(1)));

  assert_no_break_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arch_wr |-> !p_wdata[B_POS]);

  assert_done_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    arch_wr |=> done);

  assert_write_done_apart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arch_wr, done, mem_valid}));

  assert_hold_request_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .DW(DW), .B_POS(B_POS), .STACK_HI(STACK_HI), .VEC_NMI(VEC_NMI), .VEC_IRQ(VEC_IRQ)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .busy      (busy),
  .arch_wr   (arch_wr),
  .p_wdata   (p_wdata),
  .done      (done)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_n = 1'b1, nmi_n = 1'b1;
  logic        boundary = 1'b0, brk_cmd = 1'b0, rti_cmd = 1'b0;
  logic [15:0] pc_m = 16'h0000;
  logic [7:0]  p_m = 8'h24, sp_m = 8'hFF;
  logic        mem_valid, mem_we, rdy = 1'b1, stall = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, arch_wr, done;
  logic [15:0] pc_wdata;
  logic [7:0]  p_wdata, sp_wdata;
  logic [7:0]  stack [256];
  int          vectors = 0, miscompares = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] rd(input logic [15:0] a);
    case (a)
      16'hFFFA: rd = 8'hBC;
      16'hFFFB: rd = 8'h9A;
      16'hFFFE: rd = 8'hDE;
      16'hFFFF: rd = 8'hC0;
      default:  rd = (a[15:8] == 8'h01) ? stack[a[7:0]] : 8'h00;
    endcase
  endfunction

  assign mem_rdata = rd(mem_addr);

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
    .boundary(boundary), .brk_cmd(brk_cmd), .rti_cmd(rti_cmd),
    .next_pc(pc_m), .flags_in(p_m), .sp_in(sp_m),
    .mem_valid(mem_valid), .mem_ready(rdy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .arch_wr(arch_wr), .pc_wdata(pc_wdata),
    .p_wdata(p_wdata), .sp_wdata(sp_wdata), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // service the cycle ahead of the next edge, then move to the next falling edge
  task automatic tick();
    if (mem_valid && mem_we && rdy && mem_addr[15:8] == 8'h01) stack[mem_addr[7:0]] = mem_wdata;
    if (arch_wr) begin
      pc_m = pc_wdata;
      p_m  = p_wdata;
      sp_m = sp_wdata;
    end
    @(negedge clk);
    rdy = stall ? ~rdy : 1'b1;
  endtask

  task automatic strobe(input bit brk, input bit rti);
    boundary = 1'b1; brk_cmd = brk; rti_cmd = rti;
    tick();
    boundary = 1'b0; brk_cmd = 1'b0; rti_cmd = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 400) begin
      tick();
      cyc++;
    end
    chk(done === 1'b1, "R12 done reached", {15'b0, done}, 16'h1);
  endtask

  task automatic quiet_for(input int n, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (busy) seen = 1'b1;
      tick();
    end
    chk(!seen, tag, {15'b0, seen}, 16'h0);
  endtask

  task automatic t_reset();
    chk_eq("R1 busy", {15'b0, busy}, 16'h0);
    chk_eq("R1 mem_valid", {15'b0, mem_valid}, 16'h0);
    chk_eq("R1 arch_wr/done", {14'b0, arch_wr, done}, 16'h0);
  endtask

  task automatic t_irq_masked();
    p_m = 8'h24; irq_n = 1'b0;
    strobe(1'b0, 1'b0);
    quiet_for(8, "R2 masked request ignored");
    irq_n = 1'b1;
  endtask

  task automatic t_irq_entry();
    int c;
    pc_m = 16'h1234; p_m = 8'hC1; sp_m = 8'hFD; irq_n = 1'b0;
    strobe(1'b0, 1'b0);
    wait_done(c);
    irq_n = 1'b1;
    chk_eq("R12 entry latency", 16'(c), 16'd7);
    chk_eq("R5 push PCH", {8'h0, stack[8'hFD]}, 16'h0012);
    chk_eq("R5 push PCL", {8'h0, stack[8'hFC]}, 16'h0034);
    chk_eq("R7 pushed flags hw", {8'h0, stack[8'hFB]}, 16'h00C1);
    tick();
    chk_eq("R8 irq vector", pc_m, 16'hC0DE);
    chk_eq("R8 I set on entry", {8'h0, p_m}, 16'h00C5);
    chk_eq("R5 sp after entry", {8'h0, sp_m}, 16'h00FA);
  endtask

  task automatic t_rti_plain();
    int c;
    strobe(1'b0, 1'b1);
    wait_done(c);
    chk_eq("R12 return latency", 16'(c), 16'd5);
    tick();
    chk_eq("R10 pc restored exact", pc_m, 16'h1234);
    chk_eq("R10 flags restored", {8'h0, p_m}, 16'h00C1);
    chk_eq("R10 sp restored", {8'h0, sp_m}, 16'h00FD);
  endtask

  task automatic t_brk_masked();
    int c;
    pc_m = 16'h2000; p_m = 8'h24; sp_m = 8'hFF;
    strobe(1'b1, 1'b0);
    wait_done(c);
    tick();
    chk_eq("R9 break taken with I set", pc_m, 16'hC0DE);
    chk_eq("R6 break return addr", {stack[8'hFF], stack[8'hFE]}, 16'h2002);
    chk_eq("R7 pushed flags break", {8'h0, stack[8'hFD]}, 16'h0034);
    chk_eq("R8 written flags after break", {8'h0, p_m}, 16'h0024);
    strobe(1'b0, 1'b1);
    wait_done(c);
    tick();
    chk_eq("R10 break bit cleared on restore", {8'h0, p_m}, 16'h0024);
    chk_eq("R10 pc after break return", pc_m, 16'h2002);
  endtask

  task automatic t_nmi();
    int c;
    pc_m = 16'h4321; p_m = 8'h04; sp_m = 8'hF0;
    nmi_n = 1'b0;
    tick();
    strobe(1'b0, 1'b0);
    wait_done(c);
    tick();
    chk_eq("R3 nmi taken with I set", pc_m, 16'h9ABC);
    chk_eq("R6 nmi return addr", {stack[8'hF0], stack[8'hEF]}, 16'h4321);
    chk_eq("R7 nmi pushed flags", {8'h0, stack[8'hEE]}, 16'h0004);
    strobe(1'b0, 1'b0);
    quiet_for(8, "R3 held-low nmi not retaken");
    nmi_n = 1'b1;
    tick();
  endtask

  task automatic t_priority();
    int c;
    pc_m = 16'h5000; p_m = 8'h00; sp_m = 8'hFF; irq_n = 1'b0;
    nmi_n = 1'b0;
    tick();
    nmi_n = 1'b1;
    strobe(1'b1, 1'b0);
    wait_done(c);
    tick();
    chk_eq("R4 nmi wins vector", pc_m, 16'h9ABC);
    chk_eq("R4 preempted break addr", {stack[8'hFF], stack[8'hFE]}, 16'h5000);
    chk_eq("R4 preempted break flag bit", {8'h0, stack[8'hFD]}, 16'h0000);
    quiet_for(6, "R2 I set blocks irq after entry");
    irq_n = 1'b1;
  endtask

  task automatic t_reentry();
    int c;
    sp_m = 8'hF7; p_m = 8'h04; pc_m = 16'h0300;
    stack[8'hF8] = 8'h00; stack[8'hF9] = 8'h78; stack[8'hFA] = 8'h56;
    irq_n = 1'b0;
    strobe(1'b0, 1'b1);
    wait_done(c);
    tick();
    chk_eq("R11 return pc", pc_m, 16'h5678);
    chk_eq("R11 busy without boundary", {15'b0, busy}, 16'h1);
    wait_done(c);
    tick();
    irq_n = 1'b1;
    chk_eq("R11 re-entry vector", pc_m, 16'hC0DE);
    chk_eq("R11 re-entry pushed pc", {stack[8'hFA], stack[8'hF9]}, 16'h5678);
    chk_eq("R11 re-entry sp", {8'h0, sp_m}, 16'h00F7);
  endtask

  task automatic t_nmi_mid();
    int c;
    pc_m = 16'h1111; p_m = 8'h04; sp_m = 8'hFF;
    strobe(1'b1, 1'b0);
    tick();
    nmi_n = 1'b0;
    tick();
    nmi_n = 1'b1;
    wait_done(c);
    tick();
    chk_eq("R11 first handler", pc_m, 16'hC0DE);
    wait_done(c);
    tick();
    chk_eq("R11 late nmi vector", pc_m, 16'h9ABC);
    chk_eq("R11 late nmi pushed pc", {stack[8'hFC], stack[8'hFB]}, 16'hC0DE);
    chk_eq("R11 late nmi sp", {8'h0, sp_m}, 16'h00F9);
  endtask

  task automatic t_stall();
    int c;
    stall = 1'b1;
    pc_m = 16'hABCD; p_m = 8'h00; sp_m = 8'hFF; irq_n = 1'b0;
    strobe(1'b0, 1'b0);
    wait_done(c);
    irq_n = 1'b1;
    chk(c > 7, "R13 stalls lengthen entry", 16'(c), 16'd8);
    tick();
    stall = 1'b0;
    chk_eq("R13 stalled push pc", {stack[8'hFF], stack[8'hFE]}, 16'hABCD);
    chk_eq("R13 stalled flags", {8'h0, stack[8'hFD]}, 16'h0000);
    chk_eq("R13 stalled vector", pc_m, 16'hC0DE);
    tick();
  endtask

  initial begin
    for (int k = 0; k < 256; k++) stack[k] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_irq_masked();
    t_irq_entry();
    t_rti_plain();
    t_brk_masked();
    t_nmi();
    t_priority();
    t_reentry();
    t_nmi_mid();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule